// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block derives every drive signal a 2048-pixel linear image sensor needs from one fast system clock. It makes a pixel clock as an even division of the system clock, a transfer pulse that opens each new line, an active-low shutter that dumps charge so that integration only starts at a set point before the next transfer, and, in external-reset mode, one reset pulse for each pixel period. Next to the drive pins it gives a downstream sampler a one-cycle strobe with a class tag and an index for each output position of the line.

A line is one transfer pulse followed by a run of pixel clocks. Before and after the transfer pulse the pixel clock is held low for a guard interval. The line period, the shutter release point and the reset mode come in as plain register inputs. The block samples all three once per line, in the cycle the transfer pulse begins, so software can change them at any time without tearing a line.

Top module: `ccd_line_timer`

## Requirements
- R1: The first LINE_MIN = 33 + N_EFF + 6 positions of each line carry strobes in this order: 33 leading positions, N_EFF effective pixels, then 6 trailing dummies. The tag encoding is 0 = dummy, 1 = optical black, 2 = effective.
- R2: Of the leading positions (1-based), positions 14 to 31 are tagged optical black, and positions 1–13 and 32–33 are tagged dummy. The index is 0..N_EFF-1 for effective pixels and the 0-based line position for every other position.
- R3: Between the end of one transfer pulse and the start of the next, exactly max(period_i, LINE_MIN) rising pixel-clock edges occur.
- R4: The transfer pulse is high for exactly ROG_W system cycles.
- R5: The pixel clock is low throughout the transfer pulse. It is low for at least GUARD system cycles before the pulse rises and after it falls.
- R6: The pixel clock idles low, starts each line with a rising edge, has a period of CLK_DIV system cycles and stays high for CLK_DIV/2 cycles.
- R7: With a nonzero release value R, the shutter is high during the transfer pulse and goes low when the pulse falls. It returns high once, so that exactly min(R, P) rising pixel-clock edges, counting one coincident with the release, precede the next transfer pulse.
- R8: With a release value of zero, the shutter stays high for the whole line.
- R9: In external-reset mode (mode input 1), each pixel period holds one reset pulse. It starts RS_START cycles after the pixel-clock rise and lasts RS_WIDTH cycles. In internal-reset mode (mode input 0), the reset output stays low.
- R10: The pixel-valid strobe is one cycle wide and rises TAG_DELAY cycles after a pixel-clock rise. It occurs only for the first LINE_MIN positions of a line.
- R11: Period, release and mode are sampled when a transfer pulse begins. A change made during a line has no effect until the next transfer pulse.
- R12: While reset is high, the pixel clock, transfer and reset outputs and the strobe are low, and the shutter is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | PW | Requested line period in pixel clocks |
| release_i | input | PW | Shutter release, pixel clocks before transfer (0 = off) |
| ext_rst_mode_i | input | 1 | 1 = external-reset mode, 0 = internal |
| pclk_o | output | 1 | Pixel clock |
| xfer_o | output | 1 | Transfer pulse, active high |
| shut_n_o | output | 1 | Shutter, active low |
| rst_pulse_o | output | 1 | Per-pixel reset pulse |
| pix_valid_o | output | 1 | Per-position sample strobe |
| pix_tag_o | output | 2 | Position class |
| pix_idx_o | output | IW | Position index |

## Verification
The bench drives a period below the minimum, which must be raised to LINE_MIN; a design that passed the raw value through would end lines early and lose trailing strobes. It sets a release equal to or larger than the period, where a wrapping comparison would leave the shutter low into the transfer pulse. It also sets a release of one, where an off-by-one in the comparison would give zero or two pixel clocks. Every configuration change lands mid-line, so a design that applied the mode or period at once would show reset pulses or a wrong clock count in the current line. The guard checks catch a pixel clock that keeps running into the transfer pulse.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;
  localparam int LEAD_PIX  = 33;
  localparam int OB_START  = 13;
  localparam int OB_LEN    = 18;
  localparam int TRAIL_PIX = 6;

  typedef enum logic [1:0] {
    TAG_DUMMY = 2'd0,
    TAG_OB    = 2'd1,
    TAG_EFF   = 2'd2
  } pix_tag_e;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_ROG  = 2'd1,
    ST_POST = 2'd2,
    ST_RUN  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ccd_lt_seq.sv
module ccd_lt_seq
  import ccd_lt_pkg::*;
#(
  parameter int CLK_DIV  = 26,
  parameter int ROG_W    = 125,
  parameter int GUARD    = 125,
  parameter int LINE_MIN = 2087,
  parameter int PW       = 16,
  localparam int DW      = $clog2(CLK_DIV),
  localparam int CW      = $clog2(((ROG_W > GUARD) ? ROG_W : GUARD) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] release_i,
  input  logic          mode_i,
  output seq_st_e       st_o,
  output logic [DW-1:0] dcnt_o,
  output logic [PW-1:0] pix_o,
  output logic [PW-1:0] period_q_o,
  output logic [PW-1:0] release_q_o,
  output logic          mode_q_o
);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD - 1);
  localparam logic [CW-1:0] ROG_LAST   = CW'(ROG_W - 1);
  localparam logic [DW-1:0] DIV_LAST   = DW'(CLK_DIV - 1);
  localparam logic [PW-1:0] MIN_P      = PW'(LINE_MIN);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dcnt_q;
  logic [PW-1:0] pix_q, p_q, r_q;
  logic          m_q;
  logic [PW-1:0] p_eff;

  assign p_eff = (period_i < MIN_P) ? MIN_P : period_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PRE;
      cnt_q  <= '0;
      dcnt_q <= '0;
      pix_q  <= '0;
      p_q    <= MIN_P;
      r_q    <= '0;
      m_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_PRE: begin
          if (cnt_q == GUARD_LAST) begin
            st_q  <= ST_ROG;
            cnt_q <= '0;
            p_q   <= p_eff;
            r_q   <= release_i;
            m_q   <= mode_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ROG: begin
          if (cnt_q == ROG_LAST) begin
            st_q  <= ST_POST;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_POST: begin
          if (cnt_q == GUARD_LAST) begin
            st_q   <= ST_RUN;
            cnt_q  <= '0;
            dcnt_q <= '0;
            pix_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (dcnt_q == DIV_LAST) begin
            dcnt_q <= '0;
            if (pix_q == p_q - PW'(1)) begin
              st_q  <= ST_PRE;
              pix_q <= '0;
            end else begin
              pix_q <= pix_q + 1'b1;
            end
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign st_o        = st_q;
  assign dcnt_o      = dcnt_q;
  assign pix_o       = pix_q;
  assign period_q_o  = p_q;
  assign release_q_o = r_q;
  assign mode_q_o    = m_q;

  // R11: settings move only while waiting for the transfer pulse
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_PRE) |=> ($stable(m_q) && $stable(p_q) && $stable(r_q)));

  // R3: latched period never below the frame length
  assert_period_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (p_q >= MIN_P));
endmodule

// File: rtl/ccd_lt_tagdec.sv
module ccd_lt_tagdec
  import ccd_lt_pkg::*;
#(
  parameter int N_EFF = 2048,
  parameter int PW    = 16,
  localparam int LINE_MIN = LEAD_PIX + N_EFF + TRAIL_PIX,
  localparam int IW       = $clog2(LINE_MIN)
) (
  input  logic [PW-1:0] pix_i,
  output pix_tag_e      tag_o,
  output logic [IW-1:0] idx_o,
  output logic          in_frame_o
);
  localparam logic [PW-1:0] OB_LO   = PW'(OB_START);
  localparam logic [PW-1:0] OB_HI   = PW'(OB_START + OB_LEN);
  localparam logic [PW-1:0] EFF_LO  = PW'(LEAD_PIX);
  localparam logic [PW-1:0] EFF_HI  = PW'(LEAD_PIX + N_EFF);
  localparam logic [PW-1:0] END_POS = PW'(LINE_MIN);

  always_comb begin
    tag_o      = TAG_DUMMY;
    idx_o      = IW'(pix_i);
    in_frame_o = (pix_i < END_POS);
    if (pix_i >= OB_LO && pix_i < OB_HI) begin
      tag_o = TAG_OB;
    end else if (pix_i >= EFF_LO && pix_i < EFF_HI) begin
      tag_o = TAG_EFF;
      idx_o = IW'(pix_i - EFF_LO);
    end
  end
endmodule

// File: rtl/ccd_lt_drive.sv
module ccd_lt_drive
  import ccd_lt_pkg::*;
#(
  parameter int CLK_DIV   = 26,
  parameter int TAG_DELAY = 16,
  parameter int RS_START  = 2,
  parameter int RS_WIDTH  = 8,
  parameter int PW        = 16,
  parameter int IW        = 12,
  localparam int DW       = $clog2(CLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_st_e       st_i,
  input  logic [DW-1:0] dcnt_i,
  input  logic [PW-1:0] pix_i,
  input  logic [PW-1:0] period_q_i,
  input  logic [PW-1:0] release_q_i,
  input  logic          mode_q_i,
  input  pix_tag_e      tag_i,
  input  logic [IW-1:0] idx_i,
  input  logic          in_frame_i,
  output logic          pclk_o,
  output logic          rog_o,
  output logic          shut_n_o,
  output logic          rs_o,
  output logic          valid_o,
  output logic [1:0]    tag_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [DW-1:0] HALF_C = DW'(CLK_DIV / 2);
  localparam logic [DW-1:0] RS_LO  = DW'(RS_START);
  localparam logic [DW-1:0] RS_HI  = DW'(RS_START + RS_WIDTH);
  localparam logic [DW-1:0] TAG_C  = DW'(TAG_DELAY);

  logic          run;
  logic [PW:0]   rel_sum;
  logic          shut_low, pclk_n, rs_n, valid_n;

  assign run      = (st_i == ST_RUN);
  assign rel_sum  = {1'b0, pix_i} + {1'b0, release_q_i};
  assign shut_low = (release_q_i != '0) &&
                    ((st_i == ST_POST) || (run && (rel_sum < {1'b0, period_q_i})));
  assign pclk_n   = run && (dcnt_i < HALF_C);
  assign rs_n     = mode_q_i && run && (dcnt_i >= RS_LO) && (dcnt_i < RS_HI);
  assign valid_n  = run && (dcnt_i == TAG_C) && in_frame_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_o   <= 1'b0;
      rog_o    <= 1'b0;
      shut_n_o <= 1'b1;
      rs_o     <= 1'b0;
      valid_o  <= 1'b0;
      tag_o    <= TAG_DUMMY;
      idx_o    <= '0;
    end else begin
      pclk_o   <= pclk_n;
      rog_o    <= (st_i == ST_ROG);
      shut_n_o <= !shut_low;
      rs_o     <= rs_n;
      valid_o  <= valid_n;
      if (valid_n) begin
        tag_o <= tag_i;
        idx_o <= idx_i;
      end
    end
  end

  // R5: pixel clock parked while the transfer pulse is high
  assert_pclk_parked_R5: assert property (@(posedge clk) disable iff (rst)
    rog_o |-> !pclk_o);

  // R5: pixel clock already low on the cycle before the transfer pulse rises
  assert_guard_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rog_o) |-> !$past(pclk_o));

  // R7: shutter idle during the transfer pulse
  assert_shut_idle_in_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    rog_o |-> shut_n_o);

  // R9: reset pulse never overlaps the transfer pulse
  assert_rs_outside_xfer_R9: assert property (@(posedge clk) disable iff (rst)
    rs_o |-> !rog_o);

  // R10: strobe lasts a single cycle
  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int N_EFF     = 2048,
  parameter int CLK_DIV   = 26,
  parameter int ROG_W     = 125,
  parameter int GUARD     = 125,
  parameter int TAG_DELAY = 16,
  parameter int RS_START  = 2,
  parameter int RS_WIDTH  = 8,
  parameter int PW        = 16,
  localparam int LINE_MIN = LEAD_PIX + N_EFF + TRAIL_PIX,
  localparam int IW       = $clog2(LINE_MIN),
  localparam int DW       = $clog2(CLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] release_i,
  input  logic          ext_rst_mode_i,
  output logic          pclk_o,
  output logic          xfer_o,
  output logic          shut_n_o,
  output logic          rst_pulse_o,
  output logic          pix_valid_o,
  output logic [1:0]    pix_tag_o,
  output logic [IW-1:0] pix_idx_o
);
  if ((CLK_DIV % 2) != 0 || CLK_DIV < 4 || TAG_DELAY >= CLK_DIV ||
      RS_START + RS_WIDTH >= CLK_DIV || RS_WIDTH < 1 ||
      ROG_W < 1 || GUARD < 1 || LINE_MIN >= (1 << PW)) begin : g_bad_cfg
    $error("ccd_line_timer: parameter set out of range");
  end

  seq_st_e       st;
  logic [DW-1:0] dcnt;
  logic [PW-1:0] pix, p_q, r_q;
  logic          m_q;
  pix_tag_e      tag;
  logic [IW-1:0] idx;
  logic          in_frame;

  ccd_lt_seq #(
    .CLK_DIV(CLK_DIV), .ROG_W(ROG_W), .GUARD(GUARD),
    .LINE_MIN(LINE_MIN), .PW(PW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .period_i(period_i), .release_i(release_i), .mode_i(ext_rst_mode_i),
    .st_o(st), .dcnt_o(dcnt), .pix_o(pix),
    .period_q_o(p_q), .release_q_o(r_q), .mode_q_o(m_q)
  );

  ccd_lt_tagdec #(.N_EFF(N_EFF), .PW(PW)) u_dec (
    .pix_i(pix), .tag_o(tag), .idx_o(idx), .in_frame_o(in_frame)
  );

  ccd_lt_drive #(
    .CLK_DIV(CLK_DIV), .TAG_DELAY(TAG_DELAY), .RS_START(RS_START),
    .RS_WIDTH(RS_WIDTH), .PW(PW), .IW(IW)
  ) u_drv (
    .clk(clk), .rst(rst),
    .st_i(st), .dcnt_i(dcnt), .pix_i(pix),
    .period_q_i(p_q), .release_q_i(r_q), .mode_q_i(m_q),
    .tag_i(tag), .idx_i(idx), .in_frame_i(in_frame),
    .pclk_o(pclk_o), .rog_o(xfer_o), .shut_n_o(shut_n_o), .rs_o(rst_pulse_o),
    .valid_o(pix_valid_o), .tag_o(pix_tag_o), .idx_o(pix_idx_o)
  );
endmodule

// File: tb/ccd_line_timer_bench.sv
module ccd_line_timer_bench;
  localparam int N_EFF = 16, CLK_DIV = 6, HALF = 3, ROG_W = 5, GUARD = 4;
  localparam int TAG_DELAY = 2, RS_START = 1, RS_WIDTH = 2, PW = 12;
  localparam int LINE_MIN = 33 + N_EFF + 6;
  localparam int IW = $clog2(LINE_MIN);

  logic clk = 1'b0, rst = 1'b1;
  logic [PW-1:0] period = '0, rel = '0;
  logic mode = 1'b0;
  logic pclk, xfer, shut_n, rsp, valid;
  logic [1:0] tag;
  logic [IW-1:0] idx;

  ccd_line_timer #(
    .N_EFF(N_EFF), .CLK_DIV(CLK_DIV), .ROG_W(ROG_W), .GUARD(GUARD),
    .TAG_DELAY(TAG_DELAY), .RS_START(RS_START), .RS_WIDTH(RS_WIDTH), .PW(PW)
  ) u_ccd_line_timer (
    .clk(clk), .rst(rst), .period_i(period), .release_i(rel),
    .ext_rst_mode_i(mode), .pclk_o(pclk), .xfer_o(xfer), .shut_n_o(shut_n),
    .rst_pulse_o(rsp), .pix_valid_o(valid), .pix_tag_o(tag), .pix_idx_o(idx)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { int t; int i; } exp_t;
  exp_t q[$];

  // scoreboard driver: expected strobes of one line
  task automatic push_line();
    for (int p = 0; p < LINE_MIN; p++) begin
      exp_t e;
      e.i = p;
      if (p >= 13 && p < 31) e.t = 1;
      else if (p >= 33 && p < 33 + N_EFF) begin e.t = 2; e.i = p - 33; end
      else e.t = 0;
      q.push_back(e);
    end
  endtask

  bit p_pclk = 0, p_xfer = 0, p_shut = 1, p_rs = 0;
  bit armed = 0, first_in_line = 0, shut_rel = 0, shut_low_seen = 0;
  int exp_P, exp_R, exp_M;
  int rises, after_shut, rs_cnt, since_rise = 1000, since_fall = 1000;
  int since_xfall = 1000, hi_len, xfer_len, rs_len;

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      since_rise++; since_fall++; since_xfall++;
      if (xfer) xfer_len++;
      if (pclk && p_pclk) hi_len++;
      if (rsp && p_rs) rs_len++;
      if (!shut_n) shut_low_seen = 1;

      if (xfer && !p_xfer) begin
        check(!pclk && since_fall >= GUARD, "R5", "pclk low before transfer", since_fall, GUARD);
        check(shut_n, "R7", "shutter high at transfer", shut_n, 1);
        if (armed) begin
          check(rises == exp_P, "R3", "pixel clocks per line", rises, exp_P);
          if (exp_R != 0)
            check(after_shut == ((exp_R < exp_P) ? exp_R : exp_P), "R7",
                  "pixel clocks after release", after_shut, (exp_R < exp_P) ? exp_R : exp_P);
          else
            check(!shut_low_seen, "R8", "shutter stayed high", shut_low_seen, 0);
          check(rs_cnt == (exp_M ? exp_P : 0), "R9", "reset pulses per line", rs_cnt, exp_M ? exp_P : 0);
          check(q.size() == 0, "R10", "strobes missing in line", q.size(), 0);
        end
        exp_P = (int'(period) < LINE_MIN) ? LINE_MIN : int'(period);
        exp_R = int'(rel);
        exp_M = int'(mode);
        q.delete();
        push_line();
        armed = 1; rises = 0; after_shut = 0; rs_cnt = 0;
        shut_rel = 0; shut_low_seen = 0; xfer_len = 1;
      end

      if (!xfer && p_xfer) begin
        check(xfer_len == ROG_W, "R4", "transfer width", xfer_len, ROG_W);
        check(shut_n == (exp_R == 0), "R7", "shutter at transfer end", shut_n, exp_R == 0);
        since_xfall = 0; first_in_line = 1;
      end

      if (!shut_n && p_shut && !(!xfer && p_xfer))
        check(0, "R7", "shutter fell mid-line", 0, 1);
      if (shut_n && !p_shut) shut_rel = 1;

      if (pclk && !p_pclk && armed) begin
        rises++;
        if (shut_rel) after_shut++;
        if (first_in_line) begin
          check(since_xfall >= GUARD, "R5", "pclk low after transfer", since_xfall, GUARD);
          first_in_line = 0;
        end else begin
          check(since_rise == CLK_DIV, "R6", "pclk period", since_rise, CLK_DIV);
        end
        since_rise = 0; hi_len = 1;
      end
      if (!pclk && p_pclk) begin
        check(hi_len == HALF, "R6", "pclk high time", hi_len, HALF);
        since_fall = 0;
      end

      if (rsp && !p_rs && armed) begin
        rs_cnt++; rs_len = 1;
        check(exp_M == 1, "R11", "reset pulse in internal-mode line", rsp, 0);
        check(since_rise == RS_START, "R9", "reset pulse start", since_rise, RS_START);
      end
      if (!rsp && p_rs && armed)
        check(rs_len == RS_WIDTH, "R9", "reset pulse width", rs_len, RS_WIDTH);

      if (valid && armed) begin
        check(since_rise == TAG_DELAY, "R10", "strobe delay", since_rise, TAG_DELAY);
        if (q.size() == 0) check(0, "R10", "unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(int'(tag) == e.t, "R1", "tag", tag, e.t);
          check(int'(idx) == e.i, "R2", "index", idx, e.i);
        end
      end
    end
    p_pclk = pclk; p_xfer = xfer; p_shut = shut_n; p_rs = rsp;
  end

  task automatic wait_lines(input int n);
    repeat (n) @(posedge xfer);
  endtask

  // change settings mid-line (R11)
  task automatic set_cfg(input int p, input int r, input bit m);
    @(negedge xfer);
    @(negedge clk);
    period = PW'(p); rel = PW'(r); mode = m;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!pclk && !xfer && shut_n && !rsp && !valid, "R12", "reset outputs idle",
          {pclk, xfer, shut_n, rsp, valid}, 5'b00100);
    rst = 1'b0;
    wait_lines(3);
    set_cfg(70, 10, 1);  wait_lines(3);
    set_cfg(LINE_MIN, 1, 0); wait_lines(3);
    set_cfg(60, 80, 1);  wait_lines(3);
    set_cfg(40, 55, 0);  wait_lines(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule